// File: doc/BRIEF.md
# Majority-Vote History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a small direct-mapped table, indexed by low bits of the branch address. Each entry stores the last few resolved outcomes of the branches that map to it. A lookup reads the entry for the presented address and returns the majority of its stored outcomes. An update shifts the resolved outcome into the entry for the update address.

A parameter selects a last-outcome mode. In that mode each entry holds one bit, and the prediction is simply the outcome that was last recorded there. Two counters report how many updates were seen and how many of them the entry had predicted correctly. This lets a test harness measure accuracy over a trace of branch outcomes.

Top module: `mvote_bpred`

## Requirements
- R1: After reset every entry holds all-untaken history, so every lookup predicts untaken (0), and both counters read 0.
- R2: The entry index is PC bits [INDEX_BITS+1:2], which are bits [5:2] with the default 16 entries. PC bits [1:0] and all bits above the index are ignored, so addresses 64 bytes apart alias to the same entry.
- R3: A valid update shifts the history of the indexed entry left by one. The outcome (1 = taken) enters at bit 0 and the oldest bit is dropped.
- R4: In the default mode the history is 3 bits and the prediction is taken when at least two of them are taken. For example, taken-untaken-taken predicts taken.
- R5: When the update valid input is low, no entry and no counter changes.
- R6: The lookup output is combinational. When a lookup and an update address the same entry in one cycle, the lookup returns the prediction from the history before the update.
- R7: The total counter increments by exactly one on every valid update.
- R8: The correct counter increments when the prediction of the updated entry, taken before the update, equals the resolved outcome.
- R9: With LAST_ONLY=1 each entry is one bit, reset to untaken, and the prediction repeats the last recorded outcome.
- R10: Every outcome of a trace counts toward accuracy, including the first. The trace T T T T U repeated four times scores 14 of 20 in the default mode and 12 of 20 in last-outcome mode. Strict alternation starting with T scores 1 of 20 and 0 of 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_pc_i | input | PC_W | Address of the branch being predicted |
| lookup_taken_o | output | 1 | Prediction for lookup_pc_i, 1 = taken |
| upd_valid_i | input | 1 | A resolved outcome is presented |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| total_cnt_o | output | CNT_W | Number of valid updates |
| correct_cnt_o | output | CNT_W | Number of updates whose prior prediction matched |

## Verification
The bench drives the same stimulus into a default instance and a last-outcome instance. It steps one entry through a history sequence that ends in taken-untaken-taken. A vote that used the wrong threshold would fail there, and so would a shift that kept the oldest bit, because a stale taken would outvote two new untaken outcomes. Further tests present an update address that carries junk in bits [1:0] and in the high bits, and look it up at an aliased address. These expose an index taken from the wrong bits. A same-cycle lookup and update on one entry shows whether a design forwards the new outcome too early. Fixed outcome traces compare both counters against hand-computed scores, which catches a design that skips the first outcome or scores against the post-update history.

// File: rtl/mvote_pkg.sv
package mvote_pkg;
  localparam int unsigned MAX_HIST = 7;

  function automatic int unsigned ones(input logic [MAX_HIST-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_HIST; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/mvote_vote.sv
module mvote_vote #(
  parameter int unsigned HIST_W = 3
) (
  input  logic [HIST_W-1:0] hist_i,
  output logic              taken_o
);
  import mvote_pkg::*;

  generate
    if (HIST_W == 1) begin : g_last
      assign taken_o = hist_i[0];
    end else begin : g_major
      logic [MAX_HIST-1:0] padded;
      assign padded  = MAX_HIST'(hist_i);
      assign taken_o = ones(padded) > (HIST_W / 2);
    end
  endgenerate
endmodule

// File: rtl/mvote_hist_table.sv
module mvote_hist_table #(
  parameter int unsigned INDEX_BITS = 4,
  parameter int unsigned HIST_W     = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [INDEX_BITS-1:0] wr_idx_i,
  input  logic                  wr_bit_i,
  input  logic [INDEX_BITS-1:0] rd_a_idx_i,
  output logic [HIST_W-1:0]     rd_a_o,
  output logic [HIST_W-1:0]     rd_b_o
);
  localparam int unsigned DEPTH = 1 << INDEX_BITS;

  logic [HIST_W-1:0] hist_q [DEPTH];
  logic [HIST_W-1:0] next_hist;

  assign rd_a_o = hist_q[rd_a_idx_i];
  assign rd_b_o = hist_q[wr_idx_i];

  generate
    if (HIST_W == 1) begin : g_one
      assign next_hist = wr_bit_i;
    end else begin : g_shift
      assign next_hist = {rd_b_o[HIST_W-2:0], wr_bit_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en_i) begin
      hist_q[wr_idx_i] <= next_hist;
    end
  end

  a_r3_newest_at_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> hist_q[$past(wr_idx_i)][0] == $past(wr_bit_i));

  generate
    if (HIST_W > 1) begin : g_chk
      a_r3_oldest_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> hist_q[$past(wr_idx_i)][HIST_W-1:1] == $past(rd_b_o[HIST_W-2:0]));
    end
  endgenerate
endmodule

// File: rtl/mvote_acc_cnt.sv
module mvote_acc_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] total_o,
  output logic [CNT_W-1:0] correct_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_o   <= '0;
      correct_o <= '0;
    end else if (inc_i) begin
      total_o <= total_o + 1'b1;
      if (hit_i) correct_o <= correct_o + 1'b1;
    end
  end

  a_r7_total_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> total_o == CNT_W'($past(total_o) + 1'b1));
  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(total_o) && $stable(correct_o));
  a_r8_miss_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !hit_i) |=> $stable(correct_o));
  a_r8_hit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && hit_i) |=> correct_o == CNT_W'($past(correct_o) + 1'b1));
endmodule

// File: rtl/mvote_bpred.sv
module mvote_bpred #(
  parameter int unsigned PC_W       = 32,
  parameter int unsigned INDEX_BITS = 4,
  parameter bit          LAST_ONLY  = 1'b0,
  parameter int unsigned CNT_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  lookup_pc_i,
  output logic             lookup_taken_o,
  input  logic             upd_valid_i,
  input  logic [PC_W-1:0]  upd_pc_i,
  input  logic             upd_taken_i,
  output logic [CNT_W-1:0] total_cnt_o,
  output logic [CNT_W-1:0] correct_cnt_o
);
  localparam int unsigned HIST_W = LAST_ONLY ? 1 : 3;
  localparam int unsigned IDX_LO = 2;
  localparam int unsigned IDX_HI = INDEX_BITS + IDX_LO - 1;

  logic [INDEX_BITS-1:0] lk_idx, up_idx;
  logic [HIST_W-1:0]     lk_hist, up_hist;
  logic                  up_pred;
  logic                  pc_unused;

  assign lk_idx = lookup_pc_i[IDX_HI:IDX_LO];
  assign up_idx = upd_pc_i[IDX_HI:IDX_LO];
  assign pc_unused = ^{lookup_pc_i[PC_W-1:IDX_HI+1], lookup_pc_i[IDX_LO-1:0],
                       upd_pc_i[PC_W-1:IDX_HI+1], upd_pc_i[IDX_LO-1:0]};

  mvote_hist_table #(.INDEX_BITS(INDEX_BITS), .HIST_W(HIST_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (up_idx),
    .wr_bit_i   (upd_taken_i),
    .rd_a_idx_i (lk_idx),
    .rd_a_o     (lk_hist),
    .rd_b_o     (up_hist)
  );

  mvote_vote #(.HIST_W(HIST_W)) u_vote_lk (.hist_i(lk_hist), .taken_o(lookup_taken_o));
  mvote_vote #(.HIST_W(HIST_W)) u_vote_up (.hist_i(up_hist), .taken_o(up_pred));

  mvote_acc_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (upd_valid_i),
    .hit_i     (up_pred == upd_taken_i),
    .total_o   (total_cnt_o),
    .correct_o (correct_cnt_o)
  );

  // R6: same-entry lookup sees pre-update state; both voters agree on it
  a_r6_pre_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && lk_idx == up_idx) |-> lookup_taken_o == up_pred);

  generate
    if (LAST_ONLY) begin : g_chk_last
      a_r9_repeat_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_valid_i && lk_idx == up_idx) |=>
          ($stable(lk_idx) -> lookup_taken_o == $past(upd_taken_i)));
    end else begin : g_chk_major
      a_r4_two_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_valid_i && upd_taken_i && up_hist[0] && lk_idx == up_idx) |=>
          ($stable(lk_idx) -> lookup_taken_o));
    end
  endgenerate
endmodule

// File: tb/mvote_bpred_tb_top.sv
module mvote_bpred_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] lookup_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic        pred3, pred1;
  logic [15:0] tot3, cor3, tot1, cor1;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  mvote_bpred dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .lookup_pc_i(lookup_pc), .lookup_taken_o(pred3),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken),
    .total_cnt_o(tot3), .correct_cnt_o(cor3));

  mvote_bpred #(.LAST_ONLY(1'b1)) dut1_i (
    .clk_i(clk), .rst_ni(rst_ni), .lookup_pc_i(lookup_pc), .lookup_taken_o(pred1),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken),
    .total_cnt_o(tot1), .correct_cnt_o(cor1));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] pc, input logic t);
    upd_pc = pc; upd_taken = t; upd_valid = 1'b1;
    @(posedge clk); #1;
    upd_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] pc);
    lookup_pc = pc; #1;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) begin
      look(32'(i) << 2);
      chk("R1 majority reset", int'(pred3), 0);
      chk("R9 last reset", int'(pred1), 0);
    end
    chk("R1 total", int'(tot3), 0);
    chk("R1 correct", int'(cor3), 0);
  endtask

  task automatic t_history();
    logic [6:0] outs = 7'b1010011;   // applied from bit 0: T T U U T U T
    logic [6:0] exp3 = 7'b1000110;   // 0 1 1 0 0 0 1
    for (int i = 0; i < 7; i++) begin
      step(32'h4, outs[i]);
      look(32'h4);
      chk("R3/R4 majority after shift", int'(pred3), int'(exp3[i]));
      chk("R9 repeats last", int'(pred1), int'(outs[i]));
    end
  endtask

  task automatic t_index();
    step(32'hABC0_0017, 1'b1);
    step(32'hABC0_0017, 1'b1);
    look(32'h0000_0014);
    chk("R2 index bits 5:2", int'(pred3), 1);
    look(32'h0000_0018);
    chk("R2 neighbour untouched", int'(pred3), 0);
    look(32'h0000_0056);
    chk("R2 alias upper bits", int'(pred3), 1);
  endtask

  task automatic t_no_update();
    int t0 = int'(tot3);
    upd_pc = 32'h1C; upd_taken = 1'b1; upd_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    look(32'h1C);
    chk("R5 entry unchanged", int'(pred1), 0);
    chk("R5 total unchanged", int'(tot3), t0);
  endtask

  task automatic t_same_cycle();
    step(32'h24, 1'b1);
    upd_pc = 32'h24; upd_taken = 1'b1; upd_valid = 1'b1; lookup_pc = 32'h24;
    #1;
    chk("R6 pre-update majority", int'(pred3), 0);
    @(posedge clk); #1;
    upd_valid = 1'b0; #1;
    chk("R6 post-update majority", int'(pred3), 1);
    upd_taken = 1'b0; upd_valid = 1'b1; #1;
    chk("R6 pre-update last", int'(pred1), 1);
    @(posedge clk); #1;
    upd_valid = 1'b0; #1;
    chk("R6 post-update last", int'(pred1), 0);
  endtask

  task automatic t_counters();
    int t0 = int'(tot3), c3 = int'(cor3), c1 = int'(cor1);
    repeat (3) step(32'h28, 1'b1);
    chk("R7 total +3", int'(tot3) - t0, 3);
    chk("R8 majority hits", int'(cor3) - c3, 1);
    chk("R8 last hits", int'(cor1) - c1, 2);
  endtask

  task automatic t_trace(input logic [31:0] pc, input bit alt,
                         input int e3, input int e1);
    int t0 = int'(tot3), c3 = int'(cor3), c1 = int'(cor1);
    for (int i = 0; i < 20; i++)
      step(pc, alt ? ((i % 2) == 0) : ((i % 5) != 4));
    chk("R10 trace total", int'(tot3) - t0, 20);
    chk("R10 majority score", int'(cor3) - c3, e3);
    chk("R10 last score", int'(cor1) - c1, e1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    #1;
    t_reset();
    t_history();
    t_index();
    t_no_update();
    t_same_cycle();
    t_counters();
    t_trace(32'h30, 1'b0, 14, 12);
    t_trace(32'h34, 1'b1, 1, 0);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule